// File: doc/BRIEF.md
# Two's complement adder/subtractor

This block is a purely combinational integer unit that either adds or subtracts two operands of a configurable width. One control input picks the operation. Both operations share a single ripple-carry chain of full-adder cells. For subtraction, the second operand is inverted bit by bit and a carry of one is injected at the least significant stage. This forms the two's complement of that operand without a second adder.

Besides the modular result, the unit drives two flags. The carry leaving the top stage is the unsigned flag. A separate flag reports signed overflow, meaning the exact signed result lies outside the range the chosen width can hold. A datapath can therefore use the same instance for signed and unsigned arithmetic and read whichever flag fits the operands.

Top module: `twos_addsub`

## Requirements
- R1: With `sub_en` = 0, `sum_out` equals (X + Y) modulo 2^WIDTH.
- R2: With `sub_en` = 1, `sum_out` equals (X - Y) modulo 2^WIDTH. It is formed as X plus the bitwise complement of Y plus a carry-in of one.
- R3: With `sub_en` = 0, `carry_out` is 1 exactly when the unsigned sum X + Y is 2^WIDTH or more.
- R4: With `sub_en` = 1, `carry_out` is 1 exactly when X is greater than or equal to Y as unsigned numbers, so no borrow occurs.
- R5: `ovf_out` is 1 exactly when the exact signed result lies outside -2^(WIDTH-1) to 2^(WIDTH-1)-1. Here X and Y are read as two's complement numbers, with bit WIDTH-1 as the sign bit. This holds in both modes.
- R6: Two cases never raise `ovf_out`: adding operands of opposite sign, and subtracting operands of the same sign.
- R7: At WIDTH = 4 in add mode, 0111 + 0100 gives 1011 with `ovf_out` = 1. In the same configuration, 1100 + 1010 gives 0110 with `ovf_out` = 1.
- R8: Subtracting the most negative value from a non-negative X raises `ovf_out`. Subtracting it from a negative X does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | WIDTH | First operand |
| y_in | input | WIDTH | Second operand (subtrahend when subtracting) |
| sub_en | input | 1 | Operation select: 0 adds, 1 subtracts |
| sum_out | output | WIDTH | Modular sum or difference |
| carry_out | output | 1 | Carry from the most significant stage |
| ovf_out | output | 1 | Signed overflow flag |

## Verification
The bench builds two copies of the unit: one at WIDTH = 4 and one at the default WIDTH = 8. Each copy is swept over every operand pair in both modes, so every sign combination and every carry pattern is applied. The 4-bit copy brings the worked overflow examples within reach directly. Both copies reach the extreme cases: subtracting the most negative value, adding two maximal magnitudes, and subtracting a value from itself. Every output is compared with a result computed from plain integer arithmetic.

// File: rtl/twos_addsub_pkg.sv
// Package: shared types for the adder/subtractor.
// Assumes: nothing beyond IEEE 1800-2017 types.
package twos_addsub_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

endpackage

// File: rtl/addsub_fa_cell.sv
// Module: addsub_fa_cell
// One full-adder stage. Sum is the parity of the three inputs.
// Carry is the majority of the three inputs.
// Assumes: single-bit inputs, no storage.
module addsub_fa_cell (
    input  logic a_bit,
    input  logic b_bit,
    input  logic c_in,
    output logic s_bit,
    output logic c_out
);

    // Parity sum and majority carry for this stage.
    always_comb begin
        s_bit = a_bit ^ b_bit ^ c_in;
        c_out = (a_bit & b_bit) | (a_bit & c_in) | (b_bit & c_in);
    end

endmodule

// File: rtl/addsub_y_cond.sv
// Module: addsub_y_cond
// Conditions the second operand. In subtract mode every bit is inverted;
// in add mode the operand passes through unchanged.
// Assumes: WIDTH >= 2.
module addsub_y_cond #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] y_raw,
    input  logic             invert,
    output logic [WIDTH-1:0] y_eff
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_inv
        // Per-bit XOR with the mode select.
        always_comb y_eff[g] = y_raw[g] ^ invert;
    end

    // R2: in subtract mode each output bit is the opposite of its input bit
    always_comb begin
        if (invert) begin
            // R2
            inv_chk: assert ((y_eff & y_raw) == '0 && (y_eff | y_raw) == '1)
                else $error("conditioned operand is not the complement");
        end
    end

endmodule

// File: rtl/addsub_ripple.sv
// Module: addsub_ripple
// A WIDTH-stage ripple-carry chain of full-adder cells.
// Exposes the carry into the top stage and the carry out of it.
// Assumes: WIDTH >= 2. The depth grows linearly with WIDTH.
module addsub_ripple #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_vec,
    input  logic [WIDTH-1:0] b_vec,
    input  logic             c_lsb,
    output logic [WIDTH-1:0] s_vec,
    output logic             c_into_msb,
    output logic             c_msb
);

    localparam int EXT = WIDTH + 1;

    logic [WIDTH:0] chain;

    // Seed the chain with the least significant carry.
    always_comb chain[0] = c_lsb;

    for (genvar g = 0; g < WIDTH; g++) begin : g_stage
        addsub_fa_cell u_fa (
            .a_bit (a_vec[g]),
            .b_bit (b_vec[g]),
            .c_in  (chain[g]),
            .s_bit (s_vec[g]),
            .c_out (chain[g+1])
        );
    end

    // Bring out the two top carries for the flag logic.
    always_comb begin
        c_into_msb = chain[WIDTH-1];
        c_msb      = chain[WIDTH];
    end

    logic [EXT-1:0] arith_ref;

    // Integer reference for the chain, used only by the check below.
    always_comb arith_ref = EXT'(a_vec) + EXT'(b_vec) + EXT'(c_lsb);

    // R1
    always_comb begin
        chain_sum_chk: assert ({c_msb, s_vec} == arith_ref)
            else $error("ripple chain disagrees with integer sum");
    end

endmodule

// File: rtl/addsub_ovf.sv
// Module: addsub_ovf
// Signed overflow flag. It is raised when the carry entering the sign stage
// differs from the carry leaving it.
// Assumes: the carries come from the same chain that forms the result.
module addsub_ovf (
    input  logic c_into_msb,
    input  logic c_msb,
    output logic ovf
);

    // Disagreement between the two top carries marks overflow.
    always_comb ovf = c_into_msb ^ c_msb;

endmodule

// File: rtl/twos_addsub.sv
// Module: twos_addsub (top)
// Combinational two's complement adder/subtractor on one shared ripple chain.
// Subtraction inverts Y and drives the least significant carry to one.
// Outputs are the modular result, the top carry and a signed overflow flag.
// Assumes: WIDTH >= 2. No clock, no storage.
module twos_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] y_in,
    input  logic             sub_en,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out,
    output logic             ovf_out
);

    import twos_addsub_pkg::*;

    localparam int MSB = WIDTH - 1;
    localparam int EXT = WIDTH + 1;

    op_e            op;
    logic [MSB:0]   y_cnd;
    logic           c_top_in;
    logic           c_top_out;
    logic [MSB:0]   s_int;
    logic           v_int;

    // Decode the control into the operation type.
    always_comb op = op_e'(sub_en);

    addsub_y_cond #(.WIDTH(WIDTH)) u_ycond (
        .y_raw  (y_in),
        .invert (op == OP_SUB),
        .y_eff  (y_cnd)
    );

    addsub_ripple #(.WIDTH(WIDTH)) u_chain (
        .a_vec      (x_in),
        .b_vec      (y_cnd),
        .c_lsb      (op == OP_SUB),
        .s_vec      (s_int),
        .c_into_msb (c_top_in),
        .c_msb      (c_top_out)
    );

    addsub_ovf u_ovf (
        .c_into_msb (c_top_in),
        .c_msb      (c_top_out),
        .ovf        (v_int)
    );

    // Drive the outputs from the chain and the flag logic.
    always_comb begin
        sum_out   = s_int;
        carry_out = c_top_out;
        ovf_out   = v_int;
    end

    logic [EXT-1:0] add_ref;
    logic [EXT-1:0] sub_ref;
    logic           eff_sign;

    // Integer references and the effective sign of Y, used only by the checks.
    always_comb begin
        add_ref  = EXT'(x_in) + EXT'(y_in);
        sub_ref  = EXT'(x_in) - EXT'(y_in);
        eff_sign = y_in[MSB] ^ sub_en;
    end

    // Checks that relate the ports to integer arithmetic.
    always_comb begin
        if (!sub_en) begin
            // R1
            add_sum_chk: assert (sum_out == add_ref[MSB:0])
                else $error("add result wrong");
            // R3
            add_carry_chk: assert (carry_out == add_ref[WIDTH])
                else $error("add carry wrong");
            // R6
            no_overflow_chk: assert (!(x_in[MSB] != y_in[MSB] && ovf_out))
                else $error("opposite-sign add overflowed");
        end else begin
            // R2
            sub_diff_chk: assert (sum_out == sub_ref[MSB:0])
                else $error("subtract result wrong");
            // R4
            sub_borrow_chk: assert (carry_out == (x_in >= y_in))
                else $error("subtract carry wrong");
        end
        // R5
        sign_ovf_chk: assert (ovf_out ==
                ((x_in[MSB] == eff_sign) && (sum_out[MSB] != x_in[MSB])))
            else $error("overflow flag disagrees with sign rule");
    end

endmodule

// File: tb/twos_addsub_tb_top.sv
// Bench: exhaustive sweeps at WIDTH 4 and WIDTH 8 against integer arithmetic.
module twos_addsub_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_vec = 0;
    int   n_bad = 0;
    int   cycles = 0;
    bit   done = 1'b0;

    // 125 MHz clock.
    always #4 clk = ~clk;

    // Watchdog and cycle count.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: got %0d cycles exp below 190000", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    logic [3:0] x4, y4, s4;
    logic       m4, c4, v4;
    logic [7:0] x8, y8, s8;
    logic       m8, c8, v8;

    twos_addsub #(.WIDTH(4)) dut_i (
        .x_in (x4), .y_in (y4), .sub_en (m4),
        .sum_out (s4), .carry_out (c4), .ovf_out (v4)
    );

    twos_addsub #(.WIDTH(8)) dut8_i (
        .x_in (x8), .y_in (y8), .sub_en (m8),
        .sum_out (s8), .carry_out (c8), .ovf_out (v8)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_vec = n_vec + 1;
        if (got != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: got %0d exp %0d", tag, got, exp);
        end
    endtask

    // Expected values from plain integer arithmetic.
    function automatic void model(input int w, input int x, input int y,
                                  input bit sub, output int s, output int c,
                                  output int v);
        int m, h, xs, ys, r;
        m  = 1 << w;
        h  = m / 2;
        xs = (x >= h) ? x - m : x;
        ys = (y >= h) ? y - m : y;
        r  = sub ? xs - ys : xs + ys;
        s  = ((sub ? x - y : x + y) % m + m) % m;
        c  = sub ? int'(x >= y) : int'(x + y >= m);
        v  = int'(r < -h || r > h - 1);
    endfunction

    task automatic apply4(input int x, input int y, input bit sub);
        int es, ec, ev;
        @(posedge clk);
        #1;
        x4 = 4'(x); y4 = 4'(y); m4 = sub;
        #2;
        model(4, x, y, sub, es, ec, ev);
        check(sub ? "R2 w4 diff" : "R1 w4 sum", int'(s4), es);
        check(sub ? "R4 w4 carry" : "R3 w4 carry", int'(c4), ec);
        check("R5 w4 ovf", int'(v4), ev);
        if (!sub && x4[3] != y4[3]) check("R6 w4 add mixed signs", int'(v4), 0);
        if (sub && x4[3] == y4[3]) check("R6 w4 sub same signs", int'(v4), 0);
    endtask

    task automatic apply8(input int x, input int y, input bit sub);
        int es, ec, ev;
        @(posedge clk);
        #1;
        x8 = 8'(x); y8 = 8'(y); m8 = sub;
        #2;
        model(8, x, y, sub, es, ec, ev);
        check(sub ? "R2 w8 diff" : "R1 w8 sum", int'(s8), es);
        check(sub ? "R4 w8 carry" : "R3 w8 carry", int'(c8), ec);
        check("R5 w8 ovf", int'(v8), ev);
        if (!sub && x8[7] != y8[7]) check("R6 w8 add mixed signs", int'(v8), 0);
        if (sub && x8[7] == y8[7]) check("R6 w8 sub same signs", int'(v8), 0);
    endtask

    initial begin
        x4 = '0; y4 = '0; m4 = 1'b0;
        x8 = '0; y8 = '0; m8 = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // Quiet state: zero operands in add mode give zero and no flags.
        check("R1 idle w4 sum", int'(s4), 0);
        check("R3 idle w4 carry", int'(c4), 0);
        check("R5 idle w4 ovf", int'(v4), 0);
        check("R1 idle w8 sum", int'(s8), 0);

        // R7: the two worked 4-bit overflow cases.
        apply4(7, 4, 1'b0);
        check("R7 0111+0100 sum", int'(s4), 11);
        check("R7 0111+0100 ovf", int'(v4), 1);
        apply4(12, 10, 1'b0);
        check("R7 1100+1010 sum", int'(s4), 6);
        check("R7 1100+1010 ovf", int'(v4), 1);

        // R8: subtract the most negative value.
        apply4(3, 8, 1'b1);
        check("R8 w4 pos minus min ovf", int'(v4), 1);
        apply4(13, 8, 1'b1);
        check("R8 w4 neg minus min ovf", int'(v4), 0);
        check("R8 w4 neg minus min diff", int'(s4), 5);
        apply8(0, 128, 1'b1);
        check("R8 w8 zero minus min ovf", int'(v8), 1);
        apply8(255, 128, 1'b1);
        check("R8 w8 neg minus min ovf", int'(v8), 0);

        // Exhaustive sweep at WIDTH 4.
        for (int m = 0; m < 2; m++)
            for (int x = 0; x < 16; x++)
                for (int y = 0; y < 16; y++)
                    apply4(x, y, m[0]);

        // Exhaustive sweep at WIDTH 8.
        for (int m = 0; m < 2; m++)
            for (int x = 0; x < 256; x++)
                for (int y = 0; y < 256; y++)
                    apply8(x, y, m[0]);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule